// File: doc/BRIEF.md
# Message Buffer Cache Maintenance Engine

This block sits next to a small private write-back cache and carries out bulk maintenance over a contiguous range of cache blocks that hold a message buffer. A single command gives an operation, the block address of the first block and a block count. The engine then walks the range one block at a time. For each block it looks up the line's tag, valid bit and dirty bit in a direct-mapped tag store, and it applies the operation. Blocks are 64 bytes, so every address on the block's ports is a block number and not a byte address.

There are five operations. Drop discards blocks without saving them, which suits a receive buffer whose old contents are dead. Clean-out writes dirty blocks back and then discards them, which suits a send buffer. Write-allocate installs blocks as dirty and writes back any dirty line it displaces. Receive-install accepts one incoming block per step and installs it. Transmit reads each block out, fetching it from the next level first when it misses. Dirty victims leave through a writeback request/acknowledge port, and fetches use a fill request/acknowledge port. A one-cycle done pulse ends every command.

Top module: `msgbuf_maint_engine`

## Requirements
- R1: Opcode 0 (drop) clears the valid bit of every selected block that hits, dirty or not, and raises no writeback; a later clean-out of the same range therefore produces no writeback.
- R2: Opcode 1 (clean-out) writes each selected dirty hit back, with wb_addr equal to the block address, and then invalidates it; a clean hit is invalidated silently, and a miss causes no traffic.
- R3: Opcode 2 (write-allocate) marks a hit dirty. On a miss whose victim is valid and dirty, it first writes the victim back at address {victim tag, index}. It then installs the block as valid and dirty. One command may write back several victims.
- R4: Opcode 3 (receive-install) waits for rx_valid on every block and pulses rx_take once per installed block. The block is installed valid and dirty, and a dirty victim is written back before the block is taken.
- R5: Opcode 4 (transmit) pulses tx_valid for one cycle per block with tx_addr equal to the block address. On a miss it first writes back a dirty victim, then holds fill_req with fill_addr equal to the block address until fill_ack, and installs the block as clean.
- R6: Blocks are handled in ascending address order, wrapping modulo 2^10. wb_req and wb_addr stay fixed until wb_ack, with one request outstanding at a time.
- R7: A command is accepted only in a cycle where cmd_ready is high (idle); cmd_valid while busy is ignored and causes no traffic.
- R8: done is high for exactly one cycle after the last block, and cmd_ready is high in the cycle after it; a count of 0 gives done with no traffic.
- R9: Block addresses are 10 bits: bits [3:0] select one of 16 direct-mapped lines and bits [9:4] are the tag. Opcodes 5 to 7 complete with done and have no effect on the lines.
- R10: After reset all lines are invalid, cmd_ready is high, and done, wb_req, fill_req, tx_valid and rx_take are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | Operation code |
| cmd_base | input | 10 | First block address of the range |
| cmd_count | input | 5 | Number of blocks |
| cmd_ready | output | 1 | Engine idle, command may be taken |
| done | output | 1 | One-cycle end-of-command pulse |
| wb_req | output | 1 | Writeback request |
| wb_addr | output | 10 | Block address being written back |
| wb_ack | input | 1 | Writeback accepted |
| fill_req | output | 1 | Fetch request for a missing block |
| fill_addr | output | 10 | Block address to fetch |
| fill_ack | input | 1 | Fetched block delivered |
| rx_valid | input | 1 | Incoming block available |
| rx_take | output | 1 | Incoming block consumed |
| tx_valid | output | 1 | Block read out for transmission |
| tx_addr | output | 10 | Address of the transmitted block |

## Verification
The embedded properties assume that wb_ack and fill_ack come only while the matching request is high, each lasting one cycle, and that an incoming block, once offered on rx_valid, stays offered until rx_take. The bench responds to requests only after it has seen them, lowers each acknowledge after one cycle, and holds rx_valid at a steady level between its own changes. Under these assumptions the checks can verify that requests stay stable, that at most one of the four outputs is active at a time, and that done is a single cycle wide.

// File: rtl/msgbuf_maint_pkg.sv
package msgbuf_maint_pkg;

    typedef enum logic [2:0] {
        OP_DROP  = 3'd0,
        OP_CLEAN = 3'd1,
        OP_WRALC = 3'd2,
        OP_RECV  = 3'd3,
        OP_XMIT  = 3'd4
    } maint_op_e;

    localparam logic [2:0] OP_LAST = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_WBK,
        ST_FILL,
        ST_END
    } walk_state_e;

endpackage

// File: rtl/msgbuf_tag_store.sv
module msgbuf_tag_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_valid,
    input  logic             wr_dirty
);
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic             vld;
        logic             drt;
    } line_t;

    line_t line_q [LINES];
    line_t line_d [LINES];

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            line_d[i] = line_q[i];
        end
        if (wr_en) begin
            line_d[wr_idx] = '{tag: wr_tag, vld: wr_valid, drt: wr_dirty};
        end
    end

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    line_q[g] <= '0;
                end else begin
                    line_q[g] <= line_d[g];
                end
            end
        end
    endgenerate

    assign rd_tag   = line_q[rd_idx].tag;
    assign rd_valid = line_q[rd_idx].vld;
    assign rd_dirty = line_q[rd_idx].drt;

    // R3/R4: a line is never written dirty without also being valid
    a_r3_dirty_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dirty) |-> wr_valid);

endmodule

// File: rtl/msgbuf_range_walker.sv
module msgbuf_range_walker
    import msgbuf_maint_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 6,
    parameter int CNT_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [2:0]             cmd_op,
    input  logic [TAG_W+IDX_W-1:0] cmd_base,
    input  logic [CNT_W-1:0]       cmd_count,
    output logic                   cmd_ready,
    output logic                   done,
    output logic                   wb_req,
    output logic [TAG_W+IDX_W-1:0] wb_addr,
    input  logic                   wb_ack,
    output logic                   fill_req,
    output logic [TAG_W+IDX_W-1:0] fill_addr,
    input  logic                   fill_ack,
    input  logic                   rx_valid,
    output logic                   rx_take,
    output logic                   tx_valid,
    output logic [TAG_W+IDX_W-1:0] tx_addr,
    output logic [IDX_W-1:0]       ts_idx,
    input  logic [TAG_W-1:0]       ts_rd_tag,
    input  logic                   ts_rd_valid,
    input  logic                   ts_rd_dirty,
    output logic                   ts_we,
    output logic [TAG_W-1:0]       ts_wr_tag,
    output logic                   ts_wr_valid,
    output logic                   ts_wr_dirty
);
    localparam int ADDR_W = TAG_W + IDX_W;

    typedef struct packed {
        walk_state_e       st;
        maint_op_e         op;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  rem;
        logic [ADDR_W-1:0] wb_addr;
    } walk_t;

    walk_t s_q, s_d;

    logic [TAG_W-1:0] cur_tag;
    logic             hit;
    logic             victim_dirty;
    logic             step;

    assign ts_idx       = s_q.addr[IDX_W-1:0];
    assign cur_tag      = s_q.addr[ADDR_W-1:IDX_W];
    assign hit          = ts_rd_valid && (ts_rd_tag == cur_tag);
    assign victim_dirty = ts_rd_valid && ts_rd_dirty;

    always_comb begin
        s_d         = s_q;
        step        = 1'b0;
        done        = 1'b0;
        rx_take     = 1'b0;
        tx_valid    = 1'b0;
        ts_we       = 1'b0;
        ts_wr_tag   = cur_tag;
        ts_wr_valid = 1'b0;
        ts_wr_dirty = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    s_d.op   = maint_op_e'(cmd_op);
                    s_d.addr = cmd_base;
                    s_d.rem  = cmd_count;
                    if (cmd_count == '0 || cmd_op > OP_LAST) begin
                        s_d.st = ST_END;
                    end else begin
                        s_d.st = ST_LOOK;
                    end
                end
            end
            ST_LOOK: begin
                unique case (s_q.op)
                    OP_DROP: begin
                        ts_we = hit;
                        step  = 1'b1;
                    end
                    OP_CLEAN: begin
                        if (hit && ts_rd_dirty) begin
                            s_d.wb_addr = s_q.addr;
                            s_d.st      = ST_WBK;
                        end else begin
                            ts_we = hit;
                            step  = 1'b1;
                        end
                    end
                    OP_WRALC, OP_RECV: begin
                        if (!hit && victim_dirty) begin
                            s_d.wb_addr = {ts_rd_tag, ts_idx};
                            s_d.st      = ST_WBK;
                        end else if (s_q.op == OP_WRALC || rx_valid) begin
                            rx_take     = (s_q.op == OP_RECV);
                            ts_we       = 1'b1;
                            ts_wr_valid = 1'b1;
                            ts_wr_dirty = 1'b1;
                            step        = 1'b1;
                        end
                    end
                    OP_XMIT: begin
                        if (hit) begin
                            tx_valid = 1'b1;
                            step     = 1'b1;
                        end else if (victim_dirty) begin
                            s_d.wb_addr = {ts_rd_tag, ts_idx};
                            s_d.st      = ST_WBK;
                        end else begin
                            s_d.st = ST_FILL;
                        end
                    end
                    default: step = 1'b1;
                endcase
            end
            ST_WBK: begin
                if (wb_ack) begin
                    ts_we = 1'b1;
                    if (s_q.op == OP_CLEAN) begin
                        step = 1'b1;
                    end else begin
                        s_d.st = ST_LOOK;
                    end
                end
            end
            ST_FILL: begin
                if (fill_ack) begin
                    ts_we       = 1'b1;
                    ts_wr_valid = 1'b1;
                    s_d.st      = ST_LOOK;
                end
            end
            ST_END: begin
                done   = 1'b1;
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (step) begin
            s_d.addr = s_q.addr + ADDR_W'(1);
            s_d.rem  = s_q.rem - CNT_W'(1);
            s_d.st   = (s_q.rem == CNT_W'(1)) ? ST_END : ST_LOOK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, op: OP_DROP, addr: '0, rem: '0, wb_addr: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_ready = (s_q.st == ST_IDLE);
    assign wb_req    = (s_q.st == ST_WBK);
    assign wb_addr   = s_q.wb_addr;
    assign fill_req  = (s_q.st == ST_FILL);
    assign fill_addr = s_q.addr;
    assign tx_addr   = s_q.addr;

    // R6: a writeback request and its address hold until acknowledged
    a_r6_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));

    // R5: a fill request and its address hold until acknowledged
    a_r5_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_ack) |=> (fill_req && $stable(fill_addr)));

    // R7: no traffic while the engine reports itself idle
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !(wb_req || fill_req || tx_valid || rx_take));

    // R8: done lasts a single cycle and is followed by idle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready));

    // R4: an incoming block is only consumed when offered
    a_r4_take_offered: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |-> rx_valid);

    // R6: one block action at a time
    a_r6_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_req, fill_req, tx_valid, rx_take, done}));

endmodule

// File: rtl/msgbuf_maint_engine.sv
module msgbuf_maint_engine #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 6,
    parameter int CNT_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [2:0]             cmd_op,
    input  logic [TAG_W+IDX_W-1:0] cmd_base,
    input  logic [CNT_W-1:0]       cmd_count,
    output logic                   cmd_ready,
    output logic                   done,
    output logic                   wb_req,
    output logic [TAG_W+IDX_W-1:0] wb_addr,
    input  logic                   wb_ack,
    output logic                   fill_req,
    output logic [TAG_W+IDX_W-1:0] fill_addr,
    input  logic                   fill_ack,
    input  logic                   rx_valid,
    output logic                   rx_take,
    output logic                   tx_valid,
    output logic [TAG_W+IDX_W-1:0] tx_addr
);
    logic [IDX_W-1:0] ts_idx;
    logic [TAG_W-1:0] ts_rd_tag;
    logic             ts_rd_valid;
    logic             ts_rd_dirty;
    logic             ts_we;
    logic [TAG_W-1:0] ts_wr_tag;
    logic             ts_wr_valid;
    logic             ts_wr_dirty;

    msgbuf_range_walker #(.IDX_W(IDX_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_base    (cmd_base),
        .cmd_count   (cmd_count),
        .cmd_ready   (cmd_ready),
        .done        (done),
        .wb_req      (wb_req),
        .wb_addr     (wb_addr),
        .wb_ack      (wb_ack),
        .fill_req    (fill_req),
        .fill_addr   (fill_addr),
        .fill_ack    (fill_ack),
        .rx_valid    (rx_valid),
        .rx_take     (rx_take),
        .tx_valid    (tx_valid),
        .tx_addr     (tx_addr),
        .ts_idx      (ts_idx),
        .ts_rd_tag   (ts_rd_tag),
        .ts_rd_valid (ts_rd_valid),
        .ts_rd_dirty (ts_rd_dirty),
        .ts_we       (ts_we),
        .ts_wr_tag   (ts_wr_tag),
        .ts_wr_valid (ts_wr_valid),
        .ts_wr_dirty (ts_wr_dirty)
    );

    msgbuf_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (ts_idx),
        .rd_tag   (ts_rd_tag),
        .rd_valid (ts_rd_valid),
        .rd_dirty (ts_rd_dirty),
        .wr_en    (ts_we),
        .wr_idx   (ts_idx),
        .wr_tag   (ts_wr_tag),
        .wr_valid (ts_wr_valid),
        .wr_dirty (ts_wr_dirty)
    );

endmodule

// File: tb/msgbuf_maint_engine_test.sv
module msgbuf_maint_engine_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [9:0] cmd_base = 10'd0;
    logic [4:0] cmd_count = 5'd0;
    logic       cmd_ready, done;
    logic       wb_req, fill_req, rx_take, tx_valid;
    logic [9:0] wb_addr, fill_addr, tx_addr;
    logic       wb_ack = 1'b0;
    logic       fill_ack = 1'b0;
    logic       rx_valid = 1'b1;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    msgbuf_maint_engine uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_base(cmd_base), .cmd_count(cmd_count), .cmd_ready(cmd_ready),
        .done(done), .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_ack(fill_ack),
        .rx_valid(rx_valid), .rx_take(rx_take), .tx_valid(tx_valid),
        .tx_addr(tx_addr)
    );

    // observed traffic
    logic [9:0] obs_wb[$];
    logic [9:0] obs_fill[$];
    logic [9:0] obs_tx[$];
    int obs_take = 0;
    int wb_wait = 0;
    int fill_wait = 0;

    always @(negedge clk) begin
        if (wb_ack) begin
            wb_ack <= 1'b0;
        end else if (wb_req) begin
            if (wb_wait == 2) begin
                obs_wb.push_back(wb_addr);
                wb_ack <= 1'b1;
                wb_wait <= 0;
            end else begin
                wb_wait <= wb_wait + 1;
            end
        end
        if (fill_ack) begin
            fill_ack <= 1'b0;
        end else if (fill_req) begin
            if (fill_wait == 1) begin
                obs_fill.push_back(fill_addr);
                fill_ack <= 1'b1;
                fill_wait <= 0;
            end else begin
                fill_wait <= fill_wait + 1;
            end
        end
        if (tx_valid) obs_tx.push_back(tx_addr);
        if (rx_take) obs_take <= obs_take + 1;
    end

    // reference model of the lines, built from the requirements
    logic       m_v[16];
    logic       m_d[16];
    logic [5:0] m_t[16];
    logic [9:0] exp_wb[$];
    logic [9:0] exp_fill[$];
    logic [9:0] exp_tx[$];
    int exp_take;

    task automatic model_cmd(input logic [2:0] op, input logic [9:0] base, input int cnt);
        logic [9:0] a;
        exp_wb.delete(); exp_fill.delete(); exp_tx.delete(); exp_take = 0;
        if (op > 3'd4) return;
        a = base;
        for (int k = 0; k < cnt; k++) begin
            int ix;
            logic hit;
            ix = int'(a[3:0]);
            hit = m_v[ix] && (m_t[ix] == a[9:4]);
            case (op)
                3'd0: if (hit) begin m_v[ix] = 1'b0; m_d[ix] = 1'b0; end
                3'd1: if (hit) begin
                    if (m_d[ix]) exp_wb.push_back(a);
                    m_v[ix] = 1'b0; m_d[ix] = 1'b0;
                end
                3'd2, 3'd3: begin
                    if (!hit && m_v[ix] && m_d[ix]) exp_wb.push_back({m_t[ix], a[3:0]});
                    m_v[ix] = 1'b1; m_d[ix] = 1'b1; m_t[ix] = a[9:4];
                    if (op == 3'd3) exp_take++;
                end
                default: begin
                    if (!hit) begin
                        if (m_v[ix] && m_d[ix]) exp_wb.push_back({m_t[ix], a[3:0]});
                        exp_fill.push_back(a);
                        m_v[ix] = 1'b1; m_d[ix] = 1'b0; m_t[ix] = a[9:4];
                    end
                    exp_tx.push_back(a);
                end
            endcase
            a = a + 10'd1;
        end
    endtask

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic compare_queues(input string tag);
        check(obs_wb.size() == exp_wb.size(), tag, "writeback count", obs_wb.size(), exp_wb.size());
        for (int i = 0; i < exp_wb.size() && i < obs_wb.size(); i++)
            check(obs_wb[i] == exp_wb[i], "R6", "writeback address in order", int'(obs_wb[i]), int'(exp_wb[i]));
        check(obs_fill.size() == exp_fill.size(), tag, "fill count", obs_fill.size(), exp_fill.size());
        for (int i = 0; i < exp_fill.size() && i < obs_fill.size(); i++)
            check(obs_fill[i] == exp_fill[i], "R5", "fill address", int'(obs_fill[i]), int'(exp_fill[i]));
        check(obs_tx.size() == exp_tx.size(), tag, "transmit count", obs_tx.size(), exp_tx.size());
        for (int i = 0; i < exp_tx.size() && i < obs_tx.size(); i++)
            check(obs_tx[i] == exp_tx[i], "R5", "transmit address", int'(obs_tx[i]), int'(exp_tx[i]));
        check(obs_take == exp_take, tag, "incoming blocks taken", obs_take, exp_take);
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [9:0] base, input int cnt, input bit inject);
        int waited;
        string tag;
        tag = op_tag(op);
        if (cnt == 0) tag = "R8";
        model_cmd(op, base, cnt);
        obs_wb.delete(); obs_fill.delete(); obs_tx.delete(); obs_take = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_base = base; cmd_count = 5'(cnt);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b0, "R7", "busy after accept", int'(cmd_ready), 0);
        if (inject) begin
            // R7: a clean-out offered while busy must be ignored
            cmd_valid = 1'b1; cmd_op = 3'd1; cmd_count = 5'd16;
            repeat (3) @(negedge clk);
            cmd_valid = 1'b0;
        end
        waited = 0;
        while (!done && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, "R8", "done seen", int'(done), 1);
        @(negedge clk);
        check(done == 1'b0, "R8", "done single cycle", int'(done), 0);
        check(cmd_ready == 1'b1, "R8", "idle after done", int'(cmd_ready), 1);
        compare_queues(tag);
    endtask

    typedef struct packed {
        logic [2:0] op;
        logic [9:0] base;
        logic [4:0] cnt;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{3'd2, 10'h010, 5'd4},
        '{3'd1, 10'h012, 5'd4},
        '{3'd1, 10'h010, 5'd4},
        '{3'd2, 10'h020, 5'd3},
        '{3'd3, 10'h030, 5'd2},
        '{3'd0, 10'h030, 5'd3},
        '{3'd1, 10'h020, 5'd3},
        '{3'd4, 10'h040, 5'd2},
        '{3'd2, 10'h051, 5'd1},
        '{3'd4, 10'h040, 5'd3},
        '{3'd2, 10'h3FE, 5'd4},
        '{3'd1, 10'h3FE, 5'd4},
        '{3'd2, 10'h100, 5'd16},
        '{3'd3, 10'h200, 5'd16},
        '{3'd6, 10'h200, 5'd3},
        '{3'd1, 10'h200, 5'd16}
    };

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_v[i] = 1'b0; m_d[i] = 1'b0; m_t[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(cmd_ready == 1'b1, "R10", "cmd_ready after reset", int'(cmd_ready), 1);
        check(!done && !wb_req && !fill_req && !tx_valid && !rx_take, "R10", "outputs quiet after reset",
              int'({done, wb_req, fill_req, tx_valid, rx_take}), 0);
        // R10: all lines invalid -> clean-out of the whole cache writes nothing
        run_cmd(3'd1, 10'h000, 16, 1'b0);

        for (int v = 0; v < NVEC; v++) begin
            run_cmd(VECS[v].op, VECS[v].base, int'(VECS[v].cnt), 1'b0);
        end

        // R8: zero count
        run_cmd(3'd2, 10'h155, 0, 1'b0);

        // R7: command offered while busy is ignored; state confirmed afterwards
        run_cmd(3'd2, 10'h300, 8, 1'b1);
        run_cmd(3'd1, 10'h300, 1, 1'b0);

        // R4: receive stalls while no incoming block is offered
        model_cmd(3'd3, 10'h380, 1);
        obs_wb.delete(); obs_fill.delete(); obs_tx.delete(); obs_take = 0;
        rx_valid = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd3; cmd_base = 10'h380; cmd_count = 5'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        begin
            int seen_done;
            seen_done = 0;
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                if (done) seen_done++;
            end
            check(seen_done == 0 && obs_take == 0, "R4", "stall without rx_valid", seen_done + obs_take, 0);
        end
        rx_valid = 1'b1;
        begin
            int waited;
            waited = 0;
            while (!done && waited < 100) begin
                @(negedge clk);
                waited++;
            end
            check(done == 1'b1, "R4", "done after rx_valid", int'(done), 1);
        end
        @(negedge clk);
        compare_queues("R4");

        // R1: drop of dirty lines leaves nothing to write back
        run_cmd(3'd2, 10'h0A0, 16, 1'b0);
        run_cmd(3'd0, 10'h0A0, 16, 1'b0);
        run_cmd(3'd1, 10'h0A0, 16, 1'b0);
        check(obs_wb.size() == 0, "R1", "no writeback after drop", obs_wb.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule